// File: doc/BRIEF.md
# Calibrated Seconds Prescaler

This block divides a 32768 Hz oscillator enable down to a one-second tick for a timekeeping chain, and corrects the rate digitally. The correction is done inside the divider at its divide-by-256 stage: in selected minutes one second is made 256 oscillator counts shorter or 128 counts longer. The selection follows a repeating 64-minute schedule driven by a 5-bit magnitude and a sign bit. Each step is worth about +4.068 ppm (positive) or -2.034 ppm (negative).

The timekeeping chain feeds a one-cycle minute-boundary pulse back so the block can track its place in the 64-minute schedule. A test enable brings out a 512 Hz square wave that stays unaffected by the calibration setting, so the oscillator error can be measured directly. A run input stops the whole block and returns it to the start of a second and of the schedule.

Top module: `calib_prescaler`

## Requirements
- R1: In a minute that is not modified, or when the magnitude is 0, every second spans exactly HI_COUNT*256 oscillator enables (32768 by default), and `sec_tick` is high for one cycle in the clock cycle after the enable that completes the second.
- R2: A minute index counts `minute_wrap` pulses and returns to minute 0 after 64 of them, so the schedule repeats every 64 minutes.
- R3: A magnitude N (0 to 31) marks minutes 0 to 2N-1 of the cycle as modified; minutes 62 and 63 are never modified.
- R4: With `cal_sign` = 1 (positive, speeds up), the adjusted second of a modified minute spans 256 fewer enables than nominal.
- R5: With `cal_sign` = 0 (negative, slows down), the adjusted second of a modified minute spans 128 more enables than nominal.
- R6: In a modified minute only the first second completed after the minute starts is adjusted; later seconds of that minute are nominal.
- R7: Magnitude and sign are sampled only when a cycle starts (on reset, on restart from `run` low, and on the `minute_wrap` that returns to minute 0); changes in between have no effect on the current cycle.
- R8: While `run` is low (or reset is asserted), `sec_tick` and `ftest_out` are low and the divider and minute index return to their start; after `run` rises the first second counts from zero in minute 0.
- R9: While `ftest_en` is high, `ftest_out` toggles once every 32 oscillator enables (512 Hz), whatever the calibration; while it is low, `ftest_out` is 0.
- R10: `sec_tick` is never raised in a cycle that does not follow a sampled oscillator enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Oscillator running; low holds the block at its start state |
| osc_en | input | 1 | One-cycle enable per oscillator period (32768 Hz) |
| minute_wrap | input | 1 | One-cycle pulse at each minute rollover of the timekeeping chain |
| cal_mag | input | MAG_W | Calibration magnitude N |
| cal_sign | input | 1 | Calibration direction: 1 positive, 0 negative |
| ftest_en | input | 1 | Enables the 512 Hz test output |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| ftest_out | output | 1 | 512 Hz test square wave |

## Verification
The hardest situation to reach is the end of a 64-minute cycle with a large magnitude: minutes 62 and 63 must fall back to nominal and minute 0 must pick up a new setting, which takes 64 minute pulses and many full seconds. The bench shrinks the upper divider stage so a second lasts 512 enables, issues a minute pulse after every one or two seconds, and runs more than two full cycles with random enable gaps, changing the calibration in mid-cycle so the sampling point is also exercised. A reference model in the bench follows the minute index and latched setting and predicts each second's length in enables.

// File: rtl/cal_div_pkg.sv
// Shared types for the calibrated seconds prescaler.
package cal_div_pkg;
    // Phase of the low divider stage: normal 256-count blocks, or the
    // extra half block that lengthens a negatively corrected second.
    typedef enum logic {
        PH_MAIN  = 1'b0,
        PH_EXTRA = 1'b1
    } div_phase_e;
endpackage

// File: rtl/cp_schedule.sv
// Correction schedule for the calibrated prescaler.
// Tracks the minute index inside a CYCLE_MIN-minute cycle, samples the
// calibration setting at each cycle start and raises adj_pend at the start of
// every minute that must carry one adjusted second. adj_pend clears when the
// divider reports that the adjusted second has ended.
// Assumes minute_wrap is a one-cycle pulse and CYCLE_MIN is a power of two.
module cp_schedule #(
    parameter int CYCLE_MIN = 64,
    parameter int MOD_MIN   = 62,
    parameter int MAG_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             minute_wrap,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_sign,
    input  logic             adj_done,
    output logic             adj_pend,
    output logic             adj_pos
);
    localparam int MW   = $clog2(CYCLE_MIN);
    localparam int CW   = ((MW > MAG_W + 1) ? MW : MAG_W + 1) + 1;
    localparam logic [MW-1:0] MIN_LAST = MW'(CYCLE_MIN - 1);
    localparam logic [CW-1:0] MOD_LIM  = CW'(MOD_MIN);

    logic [MW-1:0]    min_q;
    logic [MAG_W-1:0] mag_q;
    logic             pos_q;
    logic             pend_q;
    logic [MW-1:0]    nxt_idx;
    logic [CW-1:0]    span;
    logic             nxt_in;
    logic             start_pend;

    // Next minute index and whether that minute falls inside the window.
    always_comb begin
        nxt_idx    = (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
        span       = CW'({mag_q, 1'b0});
        nxt_in     = (CW'(nxt_idx) < span) && (CW'(nxt_idx) < MOD_LIM);
        start_pend = (cal_mag != '0) && (MOD_MIN > 0);
    end

    // Minute index, latched setting and pending-adjustment flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            min_q  <= '0;
            mag_q  <= cal_mag;
            pos_q  <= cal_sign;
            pend_q <= start_pend;
        end else if (minute_wrap) begin
            min_q <= nxt_idx;
            if (nxt_idx == '0) begin
                mag_q  <= cal_mag;
                pos_q  <= cal_sign;
                pend_q <= start_pend;
            end else begin
                pend_q <= nxt_in;
            end
        end else if (adj_done) begin
            pend_q <= 1'b0;
        end
    end

    assign adj_pend = pend_q;
    assign adj_pos  = pos_q;
endmodule

// File: rtl/cp_divider.sv
// Two-stage seconds divider with correction at the divide-by-2**LO_W stage.
// A nominal second is HI_COUNT blocks of 2**LO_W enables. A positive
// adjustment ends the second one block early; a negative one appends a partial
// block of EXT_COUNT enables. Assumes HI_COUNT >= 2 and EXT_COUNT <= 2**LO_W.
module cp_divider
    import cal_div_pkg::*;
#(
    parameter int LO_W      = 8,
    parameter int HI_COUNT  = 128,
    parameter int EXT_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic osc_en,
    input  logic adj_pend,
    input  logic adj_pos,
    output logic adj_done,
    output logic sec_tick
);
    localparam int HW = (HI_COUNT > 1) ? $clog2(HI_COUNT) : 1;
    localparam logic [LO_W-1:0] LO_LAST  = '1;
    localparam logic [LO_W-1:0] EXT_LAST = LO_W'(EXT_COUNT - 1);
    localparam logic [HW-1:0]   HI_LAST  = HW'(HI_COUNT - 1);
    localparam logic [HW-1:0]   HI_SHORT = HW'(HI_COUNT - 2);

    logic [LO_W-1:0] lo_q;
    logic [HW-1:0]   hi_q;
    div_phase_e      ph_q;
    logic            tick_q;
    logic            blk_end, ext_end, short_end, at_last, go_ext, plain_end;
    logic            sec_end;

    // Decode where the current enable lands in the second.
    always_comb begin
        blk_end   = (ph_q == PH_MAIN) && (lo_q == LO_LAST);
        ext_end   = (ph_q == PH_EXTRA) && (lo_q == EXT_LAST);
        short_end = blk_end && adj_pend && adj_pos && (hi_q == HI_SHORT);
        at_last   = blk_end && (hi_q == HI_LAST);
        go_ext    = at_last && adj_pend && !adj_pos;
        plain_end = at_last && !go_ext;
        adj_done  = osc_en && (short_end || ext_end);
        sec_end   = osc_en && (short_end || ext_end || plain_end);
    end

    // Counter stages, phase and the registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            lo_q   <= '0;
            hi_q   <= '0;
            ph_q   <= PH_MAIN;
            tick_q <= 1'b0;
        end else begin
            tick_q <= sec_end;
            if (osc_en) begin
                if (sec_end) begin
                    lo_q <= '0;
                    hi_q <= '0;
                    ph_q <= PH_MAIN;
                end else if (go_ext) begin
                    lo_q <= '0;
                    hi_q <= '0;
                    ph_q <= PH_EXTRA;
                end else if (blk_end) begin
                    lo_q <= '0;
                    hi_q <= hi_q + 1'b1;
                end else begin
                    lo_q <= lo_q + 1'b1;
                end
            end
        end
    end

    assign sec_tick = tick_q;
endmodule

// File: rtl/cp_ftest.sv
// Frequency-test output: toggles every FT_HALF oscillator enables while
// enabled, from its own counter so calibration never disturbs it.
// Assumes FT_HALF >= 2.
module cp_ftest #(
    parameter int FT_HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic osc_en,
    input  logic ftest_en,
    output logic ftest_out
);
    localparam int FW = $clog2(FT_HALF);
    localparam logic [FW-1:0] FT_LAST = FW'(FT_HALF - 1);

    logic [FW-1:0] cnt_q;
    logic          out_q;

    // Half-period counter and output toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !ftest_en) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (osc_en) begin
            if (cnt_q == FT_LAST) begin
                cnt_q <= '0;
                out_q <= ~out_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ftest_out = out_q;
endmodule

// File: rtl/calib_prescaler.sv
// Calibrated seconds prescaler: oscillator enable in, one-second tick out,
// with periodic count correction on a CYCLE_MIN-minute schedule and a
// calibration-independent frequency-test output.
// Assumes minute_wrap comes from the timekeeping chain fed by sec_tick.
module calib_prescaler #(
    parameter int LO_W      = 8,
    parameter int HI_COUNT  = 128,
    parameter int EXT_COUNT = 128,
    parameter int CYCLE_MIN = 64,
    parameter int MOD_MIN   = 62,
    parameter int MAG_W     = 5,
    parameter int FT_HALF   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             osc_en,
    input  logic             minute_wrap,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_sign,
    input  logic             ftest_en,
    output logic             sec_tick,
    output logic             ftest_out
);
    logic adj_pend;
    logic adj_pos;
    logic adj_done;

    cp_schedule #(
        .CYCLE_MIN (CYCLE_MIN),
        .MOD_MIN   (MOD_MIN),
        .MAG_W     (MAG_W)
    ) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .minute_wrap (minute_wrap),
        .cal_mag     (cal_mag),
        .cal_sign    (cal_sign),
        .adj_done    (adj_done),
        .adj_pend    (adj_pend),
        .adj_pos     (adj_pos)
    );

    cp_divider #(
        .LO_W      (LO_W),
        .HI_COUNT  (HI_COUNT),
        .EXT_COUNT (EXT_COUNT)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .osc_en   (osc_en),
        .adj_pend (adj_pend),
        .adj_pos  (adj_pos),
        .adj_done (adj_done),
        .sec_tick (sec_tick)
    );

    cp_ftest #(
        .FT_HALF (FT_HALF)
    ) u_ft (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .osc_en    (osc_en),
        .ftest_en  (ftest_en),
        .ftest_out (ftest_out)
    );
endmodule

// File: rtl/calib_prescaler_chk.sv
// Property checker for calib_prescaler, attached by bind below.
module calib_prescaler_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic osc_en,
    input logic minute_wrap,
    input logic ftest_en,
    input logic sec_tick,
    input logic ftest_out,
    input logic adj_pend,
    input logic adj_done
);
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);                                          // R1
    AST_TICK_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> $past(osc_en));                                      // R10
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!sec_tick && !ftest_out));                              // R8
    AST_FT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ftest_en |=> !ftest_out);                                        // R9
    AST_FT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && ftest_en && run) |=> $stable(ftest_out));             // R9
    AST_ONE_ADJ_PER_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_done && !minute_wrap && run) |=> !adj_pend);                 // R6
endmodule

bind calib_prescaler calib_prescaler_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .osc_en      (osc_en),
    .minute_wrap (minute_wrap),
    .ftest_en    (ftest_en),
    .sec_tick    (sec_tick),
    .ftest_out   (ftest_out),
    .adj_pend    (adj_pend),
    .adj_done    (adj_done)
);

// File: tb/calib_prescaler_bench.sv
// Bench: shortened upper stage (512-enable seconds), random enable gaps,
// reference model of the 64-minute schedule.
module calib_prescaler_bench;
    localparam int HI_N  = 2;
    localparam int NOM   = HI_N * 256;
    localparam int SHORT = NOM - 256;
    localparam int LONG  = NOM + 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b1;
    logic       osc_en = 1'b0;
    logic       minute_wrap = 1'b0;
    logic [4:0] cal_mag = 5'd3;
    logic       cal_sign = 1'b0;
    logic       ftest_en = 1'b0;
    logic       sec_tick;
    logic       ftest_out;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    int    m_idx, m_mag, m_wraps, cnt;
    bit    m_pos, m_pend, first_in_min;
    string force_tag = "";

    calib_prescaler #(.HI_COUNT(HI_N)) u_calib_prescaler (
        .clk(clk), .rst_n(rst_n), .run(run), .osc_en(osc_en),
        .minute_wrap(minute_wrap), .cal_mag(cal_mag), .cal_sign(cal_sign),
        .ftest_en(ftest_en), .sec_tick(sec_tick), .ftest_out(ftest_out)
    );

    always #10 clk = ~clk;

    function automatic bit in_win(int idx, int mag);
        return (idx < 2 * mag) && (idx < 62);
    endfunction

    function automatic int exp_len(bit pend, bit pos);
        if (!pend) return NOM;
        return pos ? SHORT : LONG;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic model_start();
        m_idx = 0; m_mag = cal_mag; m_pos = cal_sign;
        m_pend = (cal_mag != 0); first_in_min = 1'b1; cnt = 0;
    endtask

    // One-cycle minute pulse; model follows the schedule.
    task automatic do_wrap();
        minute_wrap = 1'b1;
        m_idx = (m_idx + 1) % 64; m_wraps++;
        if (m_idx == 0) begin
            m_mag = cal_mag; m_pos = cal_sign; m_pend = (cal_mag != 0);
        end else begin
            m_pend = in_win(m_idx, m_mag);
        end
        first_in_min = 1'b1;
        @(negedge clk);
        minute_wrap = 1'b0;
    endtask

    // Drive enables until a tick; compare the second's enable count.
    task automatic one_second(int dens);
        int    exp = exp_len(m_pend, m_pos);
        int    guard = 0;
        bit    prev_en = 1'b0;
        string tag;
        if (force_tag != "") tag = force_tag;
        else if (!first_in_min) tag = "R6 later second";
        else if (m_pend && m_idx == 0 && m_wraps > 0) tag = "R2 cycle restart";
        else if (m_pend) tag = m_pos ? "R4 positive" : "R5 negative";
        else if (cal_mag != m_mag || cal_sign != m_pos) tag = "R7 stale setting";
        else if (m_mag != 0) tag = "R3 outside window";
        else tag = "R1 nominal";
        force_tag = "";
        forever begin
            @(negedge clk);
            if (sec_tick) begin
                chk(cnt == exp, $sformatf("%s min=%0d", tag, m_idx), cnt, exp);
                chk(prev_en, "R10 tick after enable", prev_en, 1);
                m_pend = 1'b0; first_in_min = 1'b0; cnt = 0; osc_en = 1'b0;
                break;
            end
            guard++;
            if (guard > 4000) begin
                chk(1'b0, "R1 tick missing", cnt, exp);
                osc_en = 1'b0;
                break;
            end
            osc_en = (($urandom % 8) < dens);
            prev_en = osc_en;
            if (osc_en) cnt++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_wraps = 0;
        repeat (3) @(negedge clk);
        chk(sec_tick == 1'b0, "R8 reset tick", sec_tick, 0);
        chk(ftest_out == 1'b0, "R8 reset test out", ftest_out, 0);
        rst_n = 1'b1;
        model_start();

        // Negative magnitude 3, then a mid-cycle change that must wait.
        for (int i = 0; i < 66; i++) begin
            one_second(8);
            if (i == 10) begin cal_mag = 5'd31; cal_sign = 1'b1; end
            do_wrap();
        end

        // Random gaps, occasional two-second minutes, random setting changes.
        for (int i = 0; i < 70; i++) begin
            int nsec = (($urandom % 4) == 0) ? 2 : 1;
            for (int s = 0; s < nsec; s++) one_second(6);
            if (($urandom % 16) == 0 && i > 60) begin
                cal_mag = 5'($urandom % 32); cal_sign = 1'($urandom % 2);
            end
            do_wrap();
        end

        // Stop mid-second, restart with magnitude 0.
        for (int k = 0; k < 100; k++) begin @(negedge clk); osc_en = 1'b1; end
        @(negedge clk); osc_en = 1'b0; run = 1'b0; cal_mag = 5'd0;
        repeat (3) begin
            @(negedge clk);
            chk(sec_tick == 1'b0, "R8 held tick", sec_tick, 0);
            chk(ftest_out == 1'b0, "R8 held test out", ftest_out, 0);
        end
        run = 1'b1; model_start();
        force_tag = "R8 restart from zero";
        one_second(8);
        one_second(5);

        // Magnitude 1 positive: minutes 0 and 1 short, minute 2 nominal.
        @(negedge clk); run = 1'b0; cal_mag = 5'd1; cal_sign = 1'b1;
        @(negedge clk); run = 1'b1; model_start();
        one_second(7); do_wrap();
        one_second(7); do_wrap();
        one_second(7); do_wrap();
        // Magnitude 1 negative.
        @(negedge clk); run = 1'b0; cal_sign = 1'b0;
        @(negedge clk); run = 1'b1; model_start();
        one_second(8); do_wrap();
        one_second(8);

        // Frequency test under heavy positive calibration.
        cal_mag = 5'd31; cal_sign = 1'b1;
        @(negedge clk); run = 1'b0;
        @(negedge clk); run = 1'b1;
        begin
            int fcnt;
            int toggles = 0;
            bit prevft = 1'b0;
            ftest_en = 1'b1;
            osc_en = (($urandom % 8) < 6);
            fcnt = osc_en ? 1 : 0;
            while (toggles < 12) begin
                @(negedge clk);
                if (ftest_out != prevft) begin
                    chk(fcnt == 32, "R9 test half period", fcnt, 32);
                    fcnt = 0; toggles++; prevft = ftest_out;
                end
                if (toggles % 4 == 3) minute_wrap = (($urandom % 64) == 0);
                else minute_wrap = 1'b0;
                osc_en = (($urandom % 8) < 6);
                if (osc_en) fcnt++;
            end
        end
        minute_wrap = 1'b0;
        ftest_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(ftest_out == 1'b0, "R9 test off", ftest_out, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule